// File: doc/BRIEF.md
# Index/Data Configuration Access Bridge

This block turns the classic two-step IO-port method of reaching configuration space into single configuration requests on a downstream port. Software first writes a 32-bit index at IO port 0xCF8 that names a bus, device, function and dword register and carries an enable flag. It then reads or writes the four-byte data window at ports 0xCFC to 0xCFF. Each window access becomes one downstream request that carries byte enables, and the block holds the IO side until the matching completion returns.

A second, memory-mapped requester reaches the same targets without the index step. The target is encoded in the address offset above a 256 MB aligned base that an input selects. Both requesters share one downstream request engine, so only one access is in flight at a time.

Top module: `cfg_io_bridge`

## Requirements
- R1: After reset the index reads back as 0. A dword write to port 0xCF8 is stored, and a dword read of 0xCF8 returns it with bits 30:24 and 1:0 forced to zero. The layout is enable in bit 31, bus in 23:16, device in 15:11, function in 10:8 and dword register in 7:2.
- R2: With the enable set, an access to the data window issues one downstream request with bus, device and function taken from the index, and the dword register number zero-extended from index bits 7:2. For example, index 0x80031540 targets bus 3, device 2, function 5, dword 0x10.
- R3: Window byte enables are ((1 << n) - 1) << k, clipped to 4 bits. Here k = port - 0xCFC, and n is 1, 2 or 4 bytes for size codes 0, 1 and 2 (code 3 also means 4). Bit i enables byte i of the dword.
- R4: Window write data is shifted left by 8*k bits onto the downstream data. Completion data is shifted right by 8*k bits (zero fill) before it goes back to the IO side.
- R5: With the enable clear, a window access sends nothing downstream. A read returns 0xFFFFFFFF and a write is dropped.
- R6: Once an IO or memory request is accepted, the requester's ready stays low until its response. The downstream request stays valid with stable fields until it is accepted. The response is a one-cycle pulse in the cycle after the completion is sampled.
- R7: A memory access hits when address bits 31:28 equal the base input. It then targets bus = addr[27:20], device = addr[19:15], function = addr[14:12] and dword = addr[11:2], and passes its byte enables and data through unshifted. For example, base 0x8 and address 0x80315040 give bus 3, device 2, function 5, dword 0x10.
- R8: A memory access outside the 256 MB window sends nothing downstream. It answers in the next cycle, returning 0xFFFFFFFF for a read and dropping a write.
- R9: When both requesters are valid in the same idle cycle, the IO requester is taken and the memory ready stays low.
- R10: IO ports outside 0xCF8 and 0xCFC..0xCFF, and non-dword accesses to 0xCF8, are not claimed. They read 0xFFFFFFFF, leave the index unchanged and send nothing downstream.
- R11: In reset, both requester readies are high once idle, and no downstream request or response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_req_valid_i | input | 1 | IO request valid |
| io_req_ready_o | output | 1 | IO request accepted when high with valid |
| io_port_i | input | 16 | IO port address |
| io_size_i | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_write_i | input | 1 | 1 write, 0 read |
| io_wdata_i | input | 32 | IO write data, low-aligned |
| io_rsp_valid_o | output | 1 | IO response pulse |
| io_rdata_o | output | 32 | IO read data, low-aligned |
| mm_base_i | input | 4 | Window base address bits 31:28 |
| mm_req_valid_i | input | 1 | Memory request valid |
| mm_req_ready_o | output | 1 | Memory request accepted when high with valid |
| mm_addr_i | input | 30 | Memory dword address (bits 31:2) |
| mm_write_i | input | 1 | 1 write, 0 read |
| mm_be_i | input | 4 | Memory byte enables |
| mm_wdata_i | input | 32 | Memory write data |
| mm_rsp_valid_o | output | 1 | Memory response pulse |
| mm_rdata_o | output | 32 | Memory read data |
| cfg_req_valid_o | output | 1 | Downstream request valid |
| cfg_req_ready_i | input | 1 | Downstream request accepted |
| cfg_write_o | output | 1 | Downstream write flag |
| cfg_bus_o | output | 8 | Target bus |
| cfg_dev_o | output | 5 | Target device |
| cfg_fn_o | output | 3 | Target function |
| cfg_reg_o | output | 10 | Target dword register |
| cfg_be_o | output | 4 | Byte enables |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_cpl_valid_i | input | 1 | Completion valid |
| cfg_cpl_data_i | input | 32 | Completion read data |

## Verification
Requests that stay local (index reads, unclaimed ports, disabled window, window misses) answer exactly one cycle after the accepting edge. A forwarded request shows its downstream valid in the first cycle after acceptance and drops one cycle after the downstream ready. The response pulse appears one cycle after the completion cycle, and ready returns one cycle later. Every bench task drives inputs at the falling edge and samples at the following falling edges, at exactly those offsets. The bench checks the exact pulse cycle and the idle cycle after it, and adds a few completion wait cycles to exercise the stall.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} st_e;

  typedef struct packed {
    logic          wr;
    logic [7:0]    bus;
    logic [4:0]    dev;
    logic [2:0]    fn;
    logic [9:0]    reg_dw;
    logic [3:0]    be;
    logic [DW-1:0] wdata;
  } cfg_req_t;

  // bytes covered by size code, shifted to lane offset, clipped to the dword
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] size);
    logic [7:0] m;
    case (size)
      2'd0:    m = 8'b0000_0001;
      2'd1:    m = 8'b0000_0011;
      default: m = 8'b0000_1111;
    endcase
    m = m << off;
    return m[3:0];
  endfunction
endpackage

// File: rtl/cfgp_io_decode.sv
module cfgp_io_decode
  import cfgp_pkg::*;
#(
  parameter int          PORT_W     = 16,
  parameter logic [15:0] INDEX_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              idx_en_i,
  input  logic [21:0]       idx_tgt_i,
  output logic              is_index_o,
  output logic              fwd_o,
  output logic [1:0]        off_o,
  output cfg_req_t          req_o
);
  localparam int HI = PORT_W - 1;

  logic is_data;
  assign is_index_o = (port_i == INDEX_PORT[HI:0]) && (size_i[1] == 1'b1);
  assign is_data    = (port_i[HI:2] == DATA_PORT[HI:2]);
  assign off_o      = port_i[1:0];
  assign fwd_o      = is_data && idx_en_i;

  always_comb begin
    req_o.wr     = write_i;
    req_o.bus    = idx_tgt_i[21:14];
    req_o.dev    = idx_tgt_i[13:9];
    req_o.fn     = idx_tgt_i[8:6];
    req_o.reg_dw = {4'b0, idx_tgt_i[5:0]};
    req_o.be     = lane_mask(port_i[1:0], size_i);
    req_o.wdata  = wdata_i << {port_i[1:0], 3'b000};
  end
endmodule

// File: rtl/cfgp_mm_decode.sv
module cfgp_mm_decode
  import cfgp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 28
) (
  input  logic [ADDR_W-1:2]        addr_i,
  input  logic [ADDR_W-WIN_BITS-1:0] base_i,
  input  logic                     write_i,
  input  logic [3:0]               be_i,
  input  logic [DW-1:0]            wdata_i,
  output logic                     hit_o,
  output cfg_req_t                 req_o
);
  assign hit_o = (addr_i[ADDR_W-1:WIN_BITS] == base_i);

  always_comb begin
    req_o.wr     = write_i;
    req_o.bus    = addr_i[WIN_BITS-1 -: 8];
    req_o.dev    = addr_i[WIN_BITS-9 -: 5];
    req_o.fn     = addr_i[WIN_BITS-14 -: 3];
    req_o.reg_dw = addr_i[11:2];
    req_o.be     = be_i;
    req_o.wdata  = wdata_i;
  end
endmodule

// File: rtl/cfg_io_bridge.sv
module cfg_io_bridge
  import cfgp_pkg::*;
#(
  parameter int          PORT_W     = 16,
  parameter int          ADDR_W     = 32,
  parameter int          WIN_BITS   = 28,
  parameter logic [15:0] INDEX_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  localparam int         BASE_W     = ADDR_W - WIN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_req_valid_i,
  output logic              io_req_ready_o,
  input  logic [PORT_W-1:0] io_port_i,
  input  logic [1:0]        io_size_i,
  input  logic              io_write_i,
  input  logic [31:0]       io_wdata_i,
  output logic              io_rsp_valid_o,
  output logic [31:0]       io_rdata_o,
  input  logic [BASE_W-1:0] mm_base_i,
  input  logic              mm_req_valid_i,
  output logic              mm_req_ready_o,
  input  logic [ADDR_W-1:2] mm_addr_i,
  input  logic              mm_write_i,
  input  logic [3:0]        mm_be_i,
  input  logic [31:0]       mm_wdata_i,
  output logic              mm_rsp_valid_o,
  output logic [31:0]       mm_rdata_o,
  output logic              cfg_req_valid_o,
  input  logic              cfg_req_ready_i,
  output logic              cfg_write_o,
  output logic [7:0]        cfg_bus_o,
  output logic [4:0]        cfg_dev_o,
  output logic [2:0]        cfg_fn_o,
  output logic [9:0]        cfg_reg_o,
  output logic [3:0]        cfg_be_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic              cfg_cpl_valid_i,
  input  logic [31:0]       cfg_cpl_data_i
);
  st_e       state_q;
  logic      src_mm_q;
  logic [1:0] off_q;
  cfg_req_t  req_q;
  logic [31:0] rdata_q;
  logic      idx_en_q;
  logic [21:0] idx_tgt_q;
  logic [31:0] idx_rd;

  logic      io_is_index, io_fwd, mm_hit;
  logic [1:0] io_off;
  cfg_req_t  io_req, mm_req;

  assign idx_rd = {idx_en_q, 7'b0, idx_tgt_q, 2'b00};

  cfgp_io_decode #(
    .PORT_W(PORT_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_io_dec (
    .port_i(io_port_i), .size_i(io_size_i), .write_i(io_write_i),
    .wdata_i(io_wdata_i), .idx_en_i(idx_en_q), .idx_tgt_i(idx_tgt_q),
    .is_index_o(io_is_index), .fwd_o(io_fwd), .off_o(io_off), .req_o(io_req)
  );

  cfgp_mm_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_mm_dec (
    .addr_i(mm_addr_i), .base_i(mm_base_i), .write_i(mm_write_i),
    .be_i(mm_be_i), .wdata_i(mm_wdata_i), .hit_o(mm_hit), .req_o(mm_req)
  );

  wire idle = (state_q == ST_IDLE);
  assign io_req_ready_o = idle;
  assign mm_req_ready_o = idle && !io_req_valid_i;   // IO wins ties

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      src_mm_q  <= 1'b0;
      off_q     <= 2'b0;
      req_q     <= '0;
      rdata_q   <= '0;
      idx_en_q  <= 1'b0;
      idx_tgt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (io_req_valid_i) begin
            src_mm_q <= 1'b0;
            off_q    <= io_off;
            req_q    <= io_req;
            rdata_q  <= io_is_index ? idx_rd : '1;
            if (io_is_index && io_write_i) begin
              idx_en_q  <= io_wdata_i[31];
              idx_tgt_q <= io_wdata_i[23:2];
            end
            state_q <= io_fwd ? ST_ISSUE : ST_RESP;
          end else if (mm_req_valid_i) begin
            src_mm_q <= 1'b1;
            off_q    <= 2'b0;
            req_q    <= mm_req;
            rdata_q  <= '1;
            state_q  <= mm_hit ? ST_ISSUE : ST_RESP;
          end
        end
        ST_ISSUE: if (cfg_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (cfg_cpl_valid_i) begin
          rdata_q <= cfg_cpl_data_i >> {off_q, 3'b000};
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req_valid_o = (state_q == ST_ISSUE);
  assign cfg_write_o     = req_q.wr;
  assign cfg_bus_o       = req_q.bus;
  assign cfg_dev_o       = req_q.dev;
  assign cfg_fn_o        = req_q.fn;
  assign cfg_reg_o       = req_q.reg_dw;
  assign cfg_be_o        = req_q.be;
  assign cfg_wdata_o     = req_q.wdata;

  assign io_rsp_valid_o = (state_q == ST_RESP) && !src_mm_q;
  assign mm_rsp_valid_o = (state_q == ST_RESP) && src_mm_q;
  assign io_rdata_o     = rdata_q;
  assign mm_rdata_o     = rdata_q;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_req_ready_o,
  input logic        mm_req_ready_o,
  input logic        io_req_valid_i,
  input logic        io_rsp_valid_o,
  input logic        mm_rsp_valid_o,
  input logic        cfg_req_valid_o,
  input logic        cfg_req_ready_i,
  input logic [7:0]  cfg_bus_o,
  input logic [9:0]  cfg_reg_o,
  input logic [3:0]  cfg_be_o,
  input logic [31:0] cfg_wdata_o
);
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_valid_o && !cfg_req_ready_i |=> cfg_req_valid_o && $stable(cfg_bus_o)
      && $stable(cfg_reg_o) && $stable(cfg_be_o) && $stable(cfg_wdata_o));

  // R6
  io_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rsp_valid_o |=> !io_rsp_valid_o);

  // R6
  mm_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_rsp_valid_o |=> !mm_rsp_valid_o);

  // R6
  busy_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_valid_o |-> !io_req_ready_o && !mm_req_ready_o);

  // R6
  one_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_rsp_valid_o, mm_rsp_valid_o, cfg_req_valid_o}));

  // R3
  be_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_valid_o |-> cfg_be_o != 4'b0);

  // R9
  io_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_valid_i |-> !mm_req_ready_o);
endmodule

bind cfg_io_bridge cfgp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_req_ready_o(io_req_ready_o),
  .mm_req_ready_o(mm_req_ready_o), .io_req_valid_i(io_req_valid_i),
  .io_rsp_valid_o(io_rsp_valid_o), .mm_rsp_valid_o(mm_rsp_valid_o),
  .cfg_req_valid_o(cfg_req_valid_o), .cfg_req_ready_i(cfg_req_ready_i),
  .cfg_bus_o(cfg_bus_o), .cfg_reg_o(cfg_reg_o), .cfg_be_o(cfg_be_o),
  .cfg_wdata_o(cfg_wdata_o)
);

// File: tb/tb_cfg_io_bridge.sv
module tb_cfg_io_bridge;
  logic clk_i = 0, rst_ni = 0;
  always #2 clk_i = ~clk_i;

  logic        io_req_valid_i = 0, io_write_i = 0;
  logic [15:0] io_port_i = 0;
  logic [1:0]  io_size_i = 0;
  logic [31:0] io_wdata_i = 0;
  logic [3:0]  mm_base_i = 4'h8;
  logic        mm_req_valid_i = 0, mm_write_i = 0;
  logic [31:2] mm_addr_i = 0;
  logic [3:0]  mm_be_i = 0;
  logic [31:0] mm_wdata_i = 0;
  logic        cfg_req_ready_i = 0, cfg_cpl_valid_i = 0;
  logic [31:0] cfg_cpl_data_i = 0;
  logic        io_req_ready_o, io_rsp_valid_o, mm_req_ready_o, mm_rsp_valid_o;
  logic [31:0] io_rdata_o, mm_rdata_o, cfg_wdata_o;
  logic        cfg_req_valid_o, cfg_write_o;
  logic [7:0]  cfg_bus_o;
  logic [4:0]  cfg_dev_o;
  logic [2:0]  cfg_fn_o;
  logic [9:0]  cfg_reg_o;
  logic [3:0]  cfg_be_o;

  cfg_io_bridge dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // caller is at a falling edge; returns at the falling edge after the accepting edge
  task automatic io_go(input logic [15:0] p, input logic [1:0] sz, input logic wr, input logic [31:0] d);
    chk("R6 io ready before issue", io_req_ready_o, 1);
    io_port_i = p; io_size_i = sz; io_write_i = wr; io_wdata_i = d; io_req_valid_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    io_req_valid_i = 0;
  endtask

  task automatic mm_go(input logic [31:0] a, input logic wr, input logic [3:0] be, input logic [31:0] d);
    mm_addr_i = a[31:2]; mm_write_i = wr; mm_be_i = be; mm_wdata_i = d; mm_req_valid_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    mm_req_valid_i = 0;
  endtask

  // local answer: pulse at first falling edge after acceptance
  task automatic local_rsp(input string tag, input logic mm, input logic chk_data, input logic [31:0] exp);
    chk({tag, " no downstream"}, cfg_req_valid_o, 0);
    chk({tag, " rsp pulse"}, mm ? mm_rsp_valid_o : io_rsp_valid_o, 1);
    if (chk_data) chk({tag, " rdata"}, mm ? mm_rdata_o : io_rdata_o, exp);
    @(negedge clk_i);
    chk({tag, " rsp drop"}, mm ? mm_rsp_valid_o : io_rsp_valid_o, 0);
    chk({tag, " no downstream later"}, cfg_req_valid_o, 0);
  endtask

  task automatic svc(input string tag, input logic mm, input logic wr, input logic [7:0] bus,
                     input logic [4:0] dev, input logic [2:0] fn, input logic [9:0] rg,
                     input logic [3:0] be, input logic [31:0] wd, input int lat,
                     input logic [31:0] cpl, input logic [31:0] exp_rd);
    chk({tag, " req valid"}, cfg_req_valid_o, 1);
    chk({tag, " write"}, cfg_write_o, wr);
    chk({tag, " bus"}, cfg_bus_o, bus);
    chk({tag, " dev"}, cfg_dev_o, dev);
    chk({tag, " fn"}, cfg_fn_o, fn);
    chk({tag, " reg"}, cfg_reg_o, rg);
    chk({tag, " be"}, cfg_be_o, be);
    if (wr) chk({tag, " wdata"}, cfg_wdata_o, wd);
    chk({tag, " R6 stall"}, mm ? mm_req_ready_o : io_req_ready_o, 0);
    cfg_req_ready_i = 1;
    @(negedge clk_i);
    cfg_req_ready_i = 0;
    chk({tag, " R6 req single"}, cfg_req_valid_o, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk_i);
      chk({tag, " R6 waiting"}, mm ? mm_rsp_valid_o : io_rsp_valid_o, 0);
    end
    cfg_cpl_valid_i = 1; cfg_cpl_data_i = cpl;
    @(negedge clk_i);
    cfg_cpl_valid_i = 0;
    chk({tag, " R6 rsp pulse"}, mm ? mm_rsp_valid_o : io_rsp_valid_o, 1);
    if (!wr) chk({tag, " rdata"}, mm ? mm_rdata_o : io_rdata_o, exp_rd);
    @(negedge clk_i);
    chk({tag, " R6 rsp drop"}, mm ? mm_rsp_valid_o : io_rsp_valid_o, 0);
    chk({tag, " R6 ready back"}, mm ? mm_req_ready_o : io_req_ready_o, 1);
  endtask

  task automatic t_reset();
    chk("R11 io ready", io_req_ready_o, 1);
    chk("R11 mm ready", mm_req_ready_o, 1);
    chk("R11 req valid", cfg_req_valid_o, 0);
    chk("R11 io rsp", io_rsp_valid_o, 0);
    chk("R11 mm rsp", mm_rsp_valid_o, 0);
    io_go(16'h0CF8, 2'd2, 0, 0);
    local_rsp("R1 reset index", 0, 1, 32'h0);
  endtask

  task automatic t_index();
    io_go(16'h0CF8, 2'd2, 1, 32'hFF03_1543);
    local_rsp("R1 index write", 0, 0, 0);
    io_go(16'h0CF8, 2'd2, 0, 0);
    local_rsp("R1 index readback", 0, 1, 32'h8003_1540);
  endtask

  task automatic t_disabled();
    io_go(16'h0CF8, 2'd2, 1, 32'h0003_1540);
    local_rsp("R5 index clear", 0, 0, 0);
    io_go(16'h0CFC, 2'd2, 0, 0);
    local_rsp("R5 read disabled", 0, 1, 32'hFFFF_FFFF);
    io_go(16'h0CFD, 2'd0, 1, 32'h0000_0077);
    local_rsp("R5 write dropped", 0, 0, 0);
  endtask

  task automatic t_window();
    io_go(16'h0CF8, 2'd2, 1, 32'h8003_1540);
    local_rsp("R2 index set", 0, 0, 0);
    io_go(16'h0CFC, 2'd2, 0, 0);
    svc("R2 dword read", 0, 0, 8'd3, 5'd2, 3'd5, 10'h010, 4'b1111, 0, 3, 32'hA1B2_C3D4, 32'hA1B2_C3D4);
    io_go(16'h0CFD, 2'd0, 0, 0);
    svc("R3 R4 byte read cfd", 0, 0, 8'd3, 5'd2, 3'd5, 10'h010, 4'b0010, 0, 0, 32'hA1B2_C3D4, 32'h00A1_B2C3);
    io_go(16'h0CFE, 2'd1, 1, 32'h0000_BEEF);
    svc("R3 R4 word write cfe", 0, 1, 8'd3, 5'd2, 3'd5, 10'h010, 4'b1100, 32'hBEEF_0000, 1, 0, 0);
    io_go(16'h0CFF, 2'd0, 1, 32'h0000_005A);
    svc("R3 R4 byte write cff", 0, 1, 8'd3, 5'd2, 3'd5, 10'h010, 4'b1000, 32'h5A00_0000, 0, 0, 0);
    io_go(16'h0CFF, 2'd1, 0, 0);
    svc("R3 word clipped cff", 0, 0, 8'd3, 5'd2, 3'd5, 10'h010, 4'b1000, 0, 2, 32'h9900_0000, 32'h0000_0099);
  endtask

  task automatic t_unclaimed();
    io_go(16'h0080, 2'd2, 0, 0);
    local_rsp("R10 other port read", 0, 1, 32'hFFFF_FFFF);
    io_go(16'h0CF8, 2'd0, 0, 0);
    local_rsp("R10 byte index read", 0, 1, 32'hFFFF_FFFF);
    io_go(16'h0CF8, 2'd0, 1, 32'h0000_0000);
    local_rsp("R10 byte index write", 0, 0, 0);
    io_go(16'h0CF8, 2'd2, 0, 0);
    local_rsp("R10 index kept", 0, 1, 32'h8003_1540);
  endtask

  task automatic t_mm();
    mm_go(32'h8031_5040, 0, 4'b1111, 0);
    svc("R7 mm example", 1, 0, 8'd3, 5'd2, 3'd5, 10'h010, 4'b1111, 0, 1, 32'h1234_5678, 32'h1234_5678);
    mm_go(32'h8FFF_FF4C, 1, 4'b0101, 32'hCAFE_F00D);
    svc("R7 mm top", 1, 1, 8'hFF, 5'h1F, 3'd7, 10'h3D3, 4'b0101, 32'hCAFE_F00D, 0, 0, 0);
    mm_go(32'h9031_5040, 0, 4'b1111, 0);
    local_rsp("R8 mm miss read", 1, 1, 32'hFFFF_FFFF);
    mm_go(32'h7FFF_FFFC, 1, 4'b1111, 32'h1);
    local_rsp("R8 mm miss write", 1, 0, 0);
  endtask

  task automatic t_priority();
    io_port_i = 16'h0CF8; io_size_i = 2'd2; io_write_i = 0; io_req_valid_i = 1;
    mm_addr_i = 30'h2000_C411; mm_write_i = 0; mm_be_i = 4'b0011; mm_req_valid_i = 1; // 0x80031044
    #0;
    chk("R9 mm held off", mm_req_ready_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    io_req_valid_i = 0;
    chk("R9 io served first", io_rsp_valid_o, 1);
    chk("R9 io rdata", io_rdata_o, 32'h8003_1540);
    chk("R9 mm not yet", mm_rsp_valid_o, 0);
    @(negedge clk_i);
    chk("R9 mm ready next", mm_req_ready_o, 1);
    @(posedge clk_i); @(negedge clk_i);
    mm_req_valid_i = 0;
    svc("R9 mm after io", 1, 0, 8'd0, 5'd6, 3'd1, 10'h011, 4'b0011, 0, 0, 32'h0BAD_BEEF, 32'h0BAD_BEEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_index();
    t_disabled();
    t_window();
    t_unclaimed();
    t_mm();
    t_priority();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule